// File: doc/BRIEF.md
# Full/Empty Synchronized Word Bank

This block is a single word-addressed storage bank in which each data word carries one presence bit, read as "full" (1) or "empty" (0). Requesters present one request per cycle on a valid/ready port. Each request holds an operation code, a word address, write data and a requester tag. Every request that completes produces one response carrying read data, the requester's tag and a status bit. Two of the four request kinds are plain accesses. The other two are synchronizing accesses that wait on the presence bit. A consumer can therefore block until a producer has deposited a value, and a producer can block until the previous value has been taken.

A synchronizing request that cannot complete when it arrives is not refused. It moves into a small internal wait list, so the requester does not have to reissue it. Every entry in the list is re-examined on every cycle. When the presence bit of its word allows, the entry completes with a read-and-empty step or a write-and-fill step. Each such step is indivisible, because the bank performs only one access per cycle. Each waiting entry counts its failed retries. An entry that reaches the limit completes with a trap status, and its word is left untouched.

Top module: `fe_sync_bank`

## Requirements
- R1: Out of reset, every word holds zero with its presence bit full, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A plain load (`req_op` = 0) returns the word's data with status 0 (ok) and leaves the presence bit as it was.
- R3: A plain store (`req_op` = 1) writes the word and sets its presence bit to full. Its response carries data 0 and status 0.
- R4: A synchronizing load (`req_op` = 2) on a full word returns its data and sets the bit to empty in the same step.
- R5: A synchronizing store (`req_op` = 3) on an empty word writes the data and sets the bit to full in the same step. Its response carries data 0.
- R6: A synchronizing request whose word is in the wrong state is held inside the bank and produces no response. It completes, with no further requester action, on the first cycle it is retried and finds the bit in the needed state.
- R7: An entry that has failed TRAP_LIMIT retries completes with status 1 (trap) and data 0, and leaves the word's data and presence bit unchanged.
- R8: While any waiting entry can complete, `req_ready` is 0 and that entry is served ahead of any new request.
- R9: When several waiting entries can complete in the same cycle, the one that entered the wait list first is served first.
- R10: `req_ready` is 0 whenever the wait list holds PEND_DEPTH entries.
- R11: A response appears on the cycle after the request is accepted (or after the waiting entry is served), for exactly one cycle, and carries the request's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank accepts a request this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 sync load, 3 sync store |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Store data |
| req_tag | input | TAG_W | Requester tag, echoed in the response |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_data | output | DATA_W | Load data, zero otherwise |
| rsp_tag | output | TAG_W | Tag of the completed request |
| rsp_status | output | 1 | 0 ok, 1 trap |

## Verification
The case of interest is a retry that completes in the same cycle as a new request arrives. The bench provokes it by issuing a synchronizing store that fills a word a waiting load is blocked on, and then presenting a new request immediately after it. It also fills one word while two loads wait on it, so both become able to complete together. A behavioural reference model predicts, cycle by cycle, the value of `req_ready` and every response. The bench additionally checks the order of the response tags: the retry before the new request, and the older waiter before the younger one.

// File: rtl/fe_sync_pkg.sv
package fe_sync_pkg;
   typedef enum logic [1:0] {
      OP_LOAD   = 2'd0,
      OP_STORE  = 2'd1,
      OP_SLOAD  = 2'd2,
      OP_SSTORE = 2'd3
   } fe_op_e;

   localparam logic RSP_OK   = 1'b0;
   localparam logic RSP_TRAP = 1'b1;
   localparam logic BIT_FULL = 1'b1;
   localparam logic BIT_EMPTY = 1'b0;
endpackage

// File: rtl/fe_word_store.sv
module fe_word_store #(
   parameter int DATA_W = 64,
   parameter int ADDR_W = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         acc_addr,
   input  logic                      wr_en,
   input  logic [DATA_W-1:0]         wr_data,
   input  logic                      fe_wr_en,
   input  logic                      fe_wr_val,
   output logic [DATA_W-1:0]         rd_data,
   output logic [(1<<ADDR_W)-1:0]    fe_vec
);
   import fe_sync_pkg::*;
   localparam int WORDS = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [WORDS];
   logic [WORDS-1:0]  fe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
         fe_q <= {WORDS{BIT_FULL}};
      end else begin
         if (wr_en)    mem_q[acc_addr] <= wr_data;
         if (fe_wr_en) fe_q[acc_addr]  <= fe_wr_val;
      end
   end

   assign rd_data = mem_q[acc_addr];
   assign fe_vec  = fe_q;
endmodule

// File: rtl/fe_oldest_pick.sv
module fe_oldest_pick #(
   parameter int N = 4
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt,
   output logic [N-1:0] at_or_above
);
   always_comb begin
      logic seen;
      seen = 1'b0;
      gnt  = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i] && !seen) gnt[i] = 1'b1;
         seen = seen | req[i];
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_prefix
      assign at_or_above[g] = |gnt[g:0];
   end
endmodule

// File: rtl/fe_wait_queue.sv
module fe_wait_queue #(
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 4,
   parameter int TAG_W      = 8,
   parameter int DEPTH      = 4,
   parameter int TRAP_LIMIT = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [(1<<ADDR_W)-1:0]        fe_vec,
   input  logic                          push,
   input  logic                          push_store,
   input  logic [ADDR_W-1:0]             push_addr,
   input  logic [DATA_W-1:0]             push_wdata,
   input  logic [TAG_W-1:0]              push_tag,
   output logic [$clog2(DEPTH+1)-1:0]    occ,
   output logic                          full,
   output logic                          serve_valid,
   output logic                          serve_store,
   output logic                          serve_trap,
   output logic [ADDR_W-1:0]             serve_addr,
   output logic [DATA_W-1:0]             serve_wdata,
   output logic [TAG_W-1:0]              serve_tag
);
   localparam int CNT_W = $clog2(TRAP_LIMIT + 1);
   localparam int OCC_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(TRAP_LIMIT);

   typedef struct packed {
      logic              st;
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] wd;
      logic [TAG_W-1:0]  tag;
      logic [CNT_W-1:0]  cnt;
   } ent_t;

   ent_t             ent_q [DEPTH];
   ent_t             ent_d [DEPTH];
   ent_t             ent_x [DEPTH+1];
   logic [DEPTH-1:0] v_q, v_d;
   logic [DEPTH:0]   v_x;
   logic [DEPTH-1:0] match, elig, gnt, shift;
   logic [OCC_W-1:0] occ_q;
   ent_t             sel;

   for (genvar g = 0; g < DEPTH; g++) begin : g_eval
      assign match[g] = ent_q[g].st ? ~fe_vec[ent_q[g].addr] : fe_vec[ent_q[g].addr];
      assign elig[g]  = v_q[g] & (match[g] | (ent_q[g].cnt == CNT_MAX));
      assign ent_x[g] = ent_q[g];
   end
   assign ent_x[DEPTH] = '0;
   assign v_x          = {1'b0, v_q};

   fe_oldest_pick #(.N(DEPTH)) u_pick (
      .req         (elig),
      .gnt         (gnt),
      .at_or_above (shift)
   );

   assign serve_valid = |gnt;
   assign serve_trap  = |(gnt & ~match);

   always_comb begin
      sel = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (gnt[i]) sel = sel | ent_q[i];
      end
   end

   assign serve_store = sel.st;
   assign serve_addr  = sel.addr;
   assign serve_wdata = sel.wd;
   assign serve_tag   = sel.tag;

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         ent_t s;
         logic sv;
         s  = shift[i] ? ent_x[i+1] : ent_x[i];
         sv = shift[i] ? v_x[i+1]   : v_x[i];
         if (s.cnt != CNT_MAX) s.cnt = s.cnt + 1'b1;
         if (push && (occ_q == OCC_W'(i))) begin
            s.st   = push_store;
            s.addr = push_addr;
            s.wd   = push_wdata;
            s.tag  = push_tag;
            s.cnt  = '0;
            sv     = 1'b1;
         end
         ent_d[i] = s;
         v_d[i]   = sv;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
         v_q   <= '0;
         occ_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
         v_q <= v_d;
         if (push && !serve_valid)      occ_q <= occ_q + 1'b1;
         else if (serve_valid && !push) occ_q <= occ_q - 1'b1;
      end
   end

   assign occ  = occ_q;
   assign full = (occ_q == OCC_W'(DEPTH));
endmodule

// File: rtl/fe_sync_bank.sv
module fe_sync_bank #(
   parameter int DATA_W     = 64,
   parameter int ADDR_W     = 4,
   parameter int TAG_W      = 8,
   parameter int PEND_DEPTH = 4,
   parameter int TRAP_LIMIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic [TAG_W-1:0]  rsp_tag,
   output logic              rsp_status
);
   import fe_sync_pkg::*;
   localparam int WORDS = 1 << ADDR_W;
   localparam int OCC_W = $clog2(PEND_DEPTH + 1);

   if (PEND_DEPTH < 1) begin : g_bad_depth
      $error("PEND_DEPTH must be at least 1");
   end
   if (TRAP_LIMIT < 1) begin : g_bad_limit
      $error("TRAP_LIMIT must be at least 1");
   end
   if (ADDR_W < 1 || DATA_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("widths must be positive");
   end

   fe_op_e            op;
   logic [WORDS-1:0]  fe_vec;
   logic [OCC_W-1:0]  q_occ;
   logic              q_full;
   logic              serve_valid, serve_store, serve_trap;
   logic [ADDR_W-1:0] serve_addr;
   logic [DATA_W-1:0] serve_wdata;
   logic [TAG_W-1:0]  serve_tag;
   logic              accept, new_sync, new_can, exec_new, push;
   logic [ADDR_W-1:0] acc_addr;
   logic              wr_en, fe_wr_en, fe_wr_val;
   logic [DATA_W-1:0] wr_data, rd_data;
   logic              give_data;

   assign op        = fe_op_e'(req_op);
   assign req_ready = !q_full && !serve_valid;
   assign accept    = req_valid && req_ready;
   assign new_sync  = (op == OP_SLOAD) || (op == OP_SSTORE);
   assign new_can   = !new_sync ||
                      ((op == OP_SSTORE) ? (fe_vec[req_addr] == BIT_EMPTY)
                                         : (fe_vec[req_addr] == BIT_FULL));
   assign exec_new  = accept && new_can;
   assign push      = accept && !new_can;

   fe_wait_queue #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
      .DEPTH(PEND_DEPTH), .TRAP_LIMIT(TRAP_LIMIT)
   ) u_wait (
      .clk         (clk),
      .rst_n       (rst_n),
      .fe_vec      (fe_vec),
      .push        (push),
      .push_store  (op == OP_SSTORE),
      .push_addr   (req_addr),
      .push_wdata  (req_wdata),
      .push_tag    (req_tag),
      .occ         (q_occ),
      .full        (q_full),
      .serve_valid (serve_valid),
      .serve_store (serve_store),
      .serve_trap  (serve_trap),
      .serve_addr  (serve_addr),
      .serve_wdata (serve_wdata),
      .serve_tag   (serve_tag)
   );

   always_comb begin
      acc_addr  = req_addr;
      wr_data   = req_wdata;
      wr_en     = 1'b0;
      fe_wr_en  = 1'b0;
      fe_wr_val = BIT_FULL;
      give_data = 1'b0;
      if (serve_valid) begin
         acc_addr = serve_addr;
         wr_data  = serve_wdata;
         if (!serve_trap) begin
            wr_en     = serve_store;
            fe_wr_en  = 1'b1;
            fe_wr_val = serve_store ? BIT_FULL : BIT_EMPTY;
            give_data = !serve_store;
         end
      end else if (exec_new) begin
         unique case (op)
            OP_LOAD:   give_data = 1'b1;
            OP_STORE:  begin wr_en = 1'b1; fe_wr_en = 1'b1; fe_wr_val = BIT_FULL; end
            OP_SLOAD:  begin give_data = 1'b1; fe_wr_en = 1'b1; fe_wr_val = BIT_EMPTY; end
            OP_SSTORE: begin wr_en = 1'b1; fe_wr_en = 1'b1; fe_wr_val = BIT_FULL; end
            default:   give_data = 1'b0;
         endcase
      end
   end

   fe_word_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_addr  (acc_addr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .fe_wr_en  (fe_wr_en),
      .fe_wr_val (fe_wr_val),
      .rd_data   (rd_data),
      .fe_vec    (fe_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_data   <= '0;
         rsp_tag    <= '0;
         rsp_status <= RSP_OK;
      end else begin
         rsp_valid  <= serve_valid || exec_new;
         rsp_data   <= give_data ? rd_data : '0;
         rsp_tag    <= serve_valid ? serve_tag : req_tag;
         rsp_status <= (serve_valid && serve_trap) ? RSP_TRAP : RSP_OK;
      end
   end
endmodule

// File: rtl/fe_sync_bank_chk.sv
module fe_sync_bank_chk #(
   parameter int DATA_W     = 64,
   parameter int TAG_W      = 8,
   parameter int PEND_DEPTH = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          req_valid,
   input logic                          req_ready,
   input logic [1:0]                    req_op,
   input logic [TAG_W-1:0]              req_tag,
   input logic                          rsp_valid,
   input logic [DATA_W-1:0]             rsp_data,
   input logic [TAG_W-1:0]              rsp_tag,
   input logic                          rsp_status,
   input logic [$clog2(PEND_DEPTH+1)-1:0] occ,
   input logic                          serve_valid
);
   localparam int OCC_W = $clog2(PEND_DEPTH + 1);

   p_full_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (occ == OCC_W'(PEND_DEPTH)) |-> !req_ready);

   p_retry_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      serve_valid |-> !req_ready);

   p_plain_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_op[1]) |=> (rsp_valid && rsp_tag == $past(req_tag)));

   p_trap_no_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_status) |-> (rsp_data == '0));

   p_occ_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= OCC_W'(PEND_DEPTH));
endmodule

bind fe_sync_bank fe_sync_bank_chk #(
   .DATA_W(DATA_W), .TAG_W(TAG_W), .PEND_DEPTH(PEND_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_valid   (req_valid),
   .req_ready   (req_ready),
   .req_op      (req_op),
   .req_tag     (req_tag),
   .rsp_valid   (rsp_valid),
   .rsp_data    (rsp_data),
   .rsp_tag     (rsp_tag),
   .rsp_status  (rsp_status),
   .occ         (q_occ),
   .serve_valid (serve_valid)
);

// File: tb/sim_fe_sync_bank.sv
module sim_fe_sync_bank;
   localparam int DW = 64, AW = 4, TW = 8, PD = 4, TL = 20;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [1:0]    req_op = 2'd0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [TW-1:0] req_tag = '0;
   logic          rsp_valid;
   logic [DW-1:0] rsp_data;
   logic [TW-1:0] rsp_tag;
   logic          rsp_status;

   always #4 clk = ~clk;

   fe_sync_bank #(.DATA_W(DW), .ADDR_W(AW), .TAG_W(TW), .PEND_DEPTH(PD), .TRAP_LIMIT(TL)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_tag(req_tag),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_tag(rsp_tag), .rsp_status(rsp_status)
   );

   int n_tests = 0, n_fail = 0;
   bit done = 0;

   task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // behavioural reference model
   typedef struct {
      bit            st;
      int            addr;
      logic [DW-1:0] wd;
      logic [TW-1:0] tag;
      int            cnt;
   } pend_t;

   logic [DW-1:0] m_mem [WORDS];
   bit            m_fe  [WORDS];
   pend_t         mq[$];
   bit            e_valid;
   logic [DW-1:0] e_data;
   logic [TW-1:0] e_tag;
   bit            e_status;
   string         e_req;

   function automatic bit m_match(pend_t p);
      return p.st ? !m_fe[p.addr] : m_fe[p.addr];
   endfunction

   function automatic bit m_elig(pend_t p);
      return m_match(p) || (p.cnt >= TL);
   endfunction

   function automatic bit m_ready();
      for (int i = 0; i < mq.size(); i++) if (m_elig(mq[i])) return 1'b0;
      return mq.size() < PD;
   endfunction

   always @(posedge clk) begin
      int sel;
      bit rdy;
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) begin m_mem[w] = '0; m_fe[w] = 1'b1; end
         mq.delete();
         e_valid = 1'b0;
      end else begin
         rdy = m_ready();
         sel = -1;
         for (int i = 0; i < mq.size(); i++) if (sel < 0 && m_elig(mq[i])) sel = i;
         e_valid = 1'b0;
         if (sel >= 0) begin
            pend_t p;
            p = mq[sel];
            mq.delete(sel);
            e_valid = 1'b1; e_tag = p.tag;
            if (m_match(p)) begin
               e_status = 1'b0; e_req = "R6";
               if (p.st) begin m_mem[p.addr] = p.wd; m_fe[p.addr] = 1'b1; e_data = '0; end
               else begin e_data = m_mem[p.addr]; m_fe[p.addr] = 1'b0; end
            end else begin
               e_status = 1'b1; e_data = '0; e_req = "R7";
            end
         end
         for (int i = 0; i < mq.size(); i++) if (mq[i].cnt < TL) mq[i].cnt = mq[i].cnt + 1;
         if (sel < 0 && req_valid && rdy) begin
            int a;
            a = int'(req_addr);
            if (req_op[1] && (req_op[0] ? m_fe[a] : !m_fe[a])) begin
               pend_t n;
               n.st = req_op[0]; n.addr = a; n.wd = req_wdata; n.tag = req_tag; n.cnt = 0;
               mq.push_back(n);
            end else begin
               e_valid = 1'b1; e_tag = req_tag; e_status = 1'b0; e_data = '0;
               case (req_op)
                  2'd0: begin e_req = "R2"; e_data = m_mem[a]; end
                  2'd1: begin e_req = "R3"; m_mem[a] = req_wdata; m_fe[a] = 1'b1; end
                  2'd2: begin e_req = "R4"; e_data = m_mem[a]; m_fe[a] = 1'b0; end
                  default: begin e_req = "R5"; m_mem[a] = req_wdata; m_fe[a] = 1'b1; end
               endcase
            end
         end
      end
   end

   // per-cycle comparison, away from the edge
   logic [TW-1:0] tlog[$];
   logic [DW-1:0] last_data;
   logic [TW-1:0] last_tag = '1;
   bit            last_status;

   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         chk(req_ready == m_ready(), (mq.size() >= PD) ? "R10" : "R8", "req_ready",
             DW'(req_ready), DW'(m_ready()));
         chk(rsp_valid == e_valid, "R11", "rsp_valid", DW'(rsp_valid), DW'(e_valid));
         if (rsp_valid && e_valid) begin
            chk(rsp_tag == e_tag, e_req, "rsp_tag", DW'(rsp_tag), DW'(e_tag));
            chk(rsp_data == e_data, e_req, "rsp_data", rsp_data, e_data);
            chk(rsp_status == e_status, e_req, "rsp_status", DW'(rsp_status), DW'(e_status));
         end
         if (rsp_valid) begin
            tlog.push_back(rsp_tag);
            last_data = rsp_data; last_tag = rsp_tag; last_status = rsp_status;
         end
      end
   end

   function automatic int pos(logic [TW-1:0] t);
      for (int i = 0; i < tlog.size(); i++) if (tlog[i] == t) return i;
      return -1;
   endfunction

   task automatic send(logic [1:0] op, int addr, logic [DW-1:0] wd, logic [TW-1:0] tag);
      req_valid = 1'b1; req_op = op; req_addr = AW'(addr); req_wdata = wd; req_tag = tag;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready == 1'b1, "R1", "ready after reset", DW'(req_ready), 1);
      chk(rsp_valid == 1'b0, "R1", "no response after reset", DW'(rsp_valid), 0);

      // R1: reset contents are zero and full
      send(2'd0, 9, '0, 8'd1);
      chk(last_tag == 8'd1 && last_data == '0, "R1", "reset data", last_data, 0);
      send(2'd2, 7, '0, 8'd30);
      chk(last_tag == 8'd30 && last_status == 1'b0, "R1", "word full at reset", DW'(last_tag), 30);

      // R2/R3: plain accesses
      send(2'd1, 1, 64'hA5A5_0000_1234_5678, 8'd2);
      send(2'd0, 1, '0, 8'd3);
      chk(last_data == 64'hA5A5_0000_1234_5678, "R3", "stored data", last_data, 64'hA5A5_0000_1234_5678);

      // R4, R2 bit unchanged, R6 wait, R8 retry before new request
      send(2'd2, 1, '0, 8'd4);
      send(2'd0, 1, '0, 8'd5);
      send(2'd2, 1, '0, 8'd6);
      idle(3);
      chk(last_tag != 8'd6, "R2", "plain load left word empty", DW'(last_tag), 5);
      send(2'd3, 1, 64'h77, 8'd7);
      send(2'd0, 2, '0, 8'd8);
      idle(2);
      chk(pos(8'd7) < pos(8'd6) && pos(8'd6) < pos(8'd8), "R8", "retry before new",
          DW'(pos(8'd6)), DW'(pos(8'd7) + 1));

      // R5 with a waiting sync store on a full word
      send(2'd3, 3, 64'hBEEF, 8'd9);
      send(2'd2, 3, '0, 8'd10);
      idle(2);
      chk(pos(8'd10) >= 0 && pos(8'd10) < pos(8'd9), "R6", "sync store completes after empty",
          DW'(pos(8'd9)), DW'(pos(8'd10) + 1));
      send(2'd0, 3, '0, 8'd31);
      chk(last_data == 64'hBEEF, "R5", "sync store data", last_data, 64'hBEEF);

      // R7: trap, word untouched
      send(2'd2, 1, '0, 8'd11);
      idle(TL + 6);
      chk(last_tag == 8'd11 && last_status == 1'b1, "R7", "trap status", DW'(last_status), 1);
      send(2'd0, 1, '0, 8'd12);
      chk(last_data == 64'h77, "R7", "data unchanged by trap", last_data, 64'h77);

      // R9: two waiters, oldest first
      send(2'd2, 1, '0, 8'd13);
      send(2'd2, 1, '0, 8'd14);
      send(2'd1, 1, 64'h99, 8'd15);
      idle(TL + 6);
      chk(pos(8'd13) >= 0 && pos(8'd13) < pos(8'd14), "R9", "oldest waiter first",
          DW'(pos(8'd13)), DW'(pos(8'd14) - 1));

      // R10: fill the wait list
      send(2'd2, 4, '0, 8'd16);
      send(2'd2, 5, '0, 8'd17);
      send(2'd2, 6, '0, 8'd18);
      send(2'd2, 8, '0, 8'd19);
      send(2'd2, 4, '0, 8'd20);
      send(2'd2, 5, '0, 8'd21);
      send(2'd2, 6, '0, 8'd22);
      send(2'd2, 8, '0, 8'd23);
      chk(req_ready == 1'b0, "R10", "ready low when list full", DW'(req_ready), 0);
      send(2'd0, 0, '0, 8'd24);
      idle(TL + 8);
      chk(pos(8'd20) >= 0 && pos(8'd20) < pos(8'd24), "R10", "held request after slot frees",
          DW'(pos(8'd24)), DW'(pos(8'd20) + 1));

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule